// File: doc/BRIEF.md
# Character-Class Hash Key Generator

This block derives a shared numeric key from two ASCII strings. Both strings enter on one byte-wide stream, one byte per clock while `in_valid` is high, and `in_last` marks the final byte of each string. The first string completed after reset or after a key produces the operand p. The second string produces q. For each string the block tallies four character classes and finds the dominant one. That class selects a power-minus-product hash of two class counts.

When the second string closes, the block goes busy. It evaluates both hashes and orders the pair into a closed range [lo, hi]. It then searches the range with trial division, scanning up from lo for the smallest prime and down from hi for the largest. The key is the truncated average of those two primes, or zero with an error flag when the range holds no prime. A one-cycle strobe reports each result. The key and error flag hold until the next strobe.

Top module: `charclass_keygen`

## Requirements
- R1: Each byte falls into exactly one class: class 0 for lowercase letters 0x61..0x7A, class 1 for digits 0x30..0x39, class 2 for uppercase letters 0x41..0x5A, and class 3 for every other byte value. Each string keeps its own count per class, and counts saturate at 2^CW-1.
- R2: The winning class of a string is the class whose count is strictly greatest. On a tie the lower class number wins (0 over 1 over 2 over 3). The second operand is the count of the next class in cyclic order: 0 pairs with 1, 1 with 2, 2 with 3, and 3 with 0.
- R3: The hash of a string is x^y - x*y, where x is the winning count and y is the paired count (0^0 = 1). The power saturates at 2^VW-1 before the product is subtracted.
- R4: p comes from the first string and q from the second. The search range is lo = min(p,q) to hi = max(p,q), both ends included, so swapping the two strings gives the same result.
- R5: When the range holds a prime, the key is (smallest prime >= lo + largest prime <= hi) / 2, truncated toward zero, and key_err is 0.
- R6: When the range holds no prime, key_err is 1 and the key is 0.
- R7: key_done is high for exactly one cycle per key pair. key and key_err change only in that cycle and hold their values otherwise.
- R8: busy rises in the cycle after the last byte of the second string is accepted and falls in the cycle key_done is high. Bytes and last flags presented while busy is high are ignored.
- R9: After reset, key_done, key_err and busy are 0, the key is 0, and the next string accepted is the first string.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A string byte is present this cycle |
| in_byte | input | 8 | ASCII byte |
| in_last | input | 1 | Current byte ends its string |
| busy | output | 1 | Key computation in progress; input is ignored |
| key_done | output | 1 | One-cycle strobe: key and key_err are valid |
| key_err | output | 1 | The range held no prime |
| key | output | VW | Derived key |

## Verification
The bench builds the block with VW = 16 and CW = 8. At that width, strings of a few dozen bytes saturate the power term (R3). Trial division near the top of the value range also completes in a few hundred cycles per candidate. This lets the bench cover a saturated range whose one member is composite, which raises the error flag. It also covers a wide range that runs from 1 up to the saturated value. The two worked strings, their swapped order, ties between classes, a range whose lower prime is 2 (so the average truncates), input offered while busy, and thirty short random string pairs all run at this width against a behavioural model.

// File: rtl/keygen_pkg.sv
package keygen_pkg;
   localparam int NCLASS = 4;

   typedef enum logic [1:0] {
      CL_LOWER = 2'd0,
      CL_DIGIT = 2'd1,
      CL_UPPER = 2'd2,
      CL_OTHER = 2'd3
   } chclass_e;

   // R1: byte to class mapping
   function automatic chclass_e classify(input logic [7:0] ch);
      if (ch >= 8'h61 && ch <= 8'h7a) return CL_LOWER;
      if (ch >= 8'h30 && ch <= 8'h39) return CL_DIGIT;
      if (ch >= 8'h41 && ch <= 8'h5a) return CL_UPPER;
      return CL_OTHER;
   endfunction
endpackage

// File: rtl/kg_class_tally.sv
module kg_class_tally
   import keygen_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          clr,
   input  logic [7:0]    ch,
   output logic [CW-1:0] win_x,
   output logic [CW-1:0] win_y
);
   localparam logic [CW-1:0] CMAX = '1;

   logic [NCLASS-1:0][CW-1:0] cnt_q, cnt_n;
   logic [1:0]                cls_idx;
   logic [1:0]                best;

   assign cls_idx = classify(ch);

   // R1: counts including the byte presented this cycle
   always_comb begin
      cnt_n = cnt_q;
      for (int i = 0; i < NCLASS; i++) begin
         if (inc && cls_idx == 2'(i) && cnt_q[i] != CMAX)
            cnt_n[i] = cnt_q[i] + 1'b1;
      end
   end

   // R2: strict maximum, lowest class index keeps a tie
   always_comb begin
      best = 2'd0;
      for (int i = 1; i < NCLASS; i++) begin
         if (cnt_n[i] > cnt_n[best]) best = 2'(i);
      end
   end

   assign win_x = cnt_n[best];
   assign win_y = cnt_n[best + 2'd1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (inc) cnt_q <= clr ? '0 : cnt_n;
   end
endmodule

// File: rtl/kg_hash_eval.sv
module kg_hash_eval #(
   parameter int VW = 32,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] x,
   input  logic [CW-1:0] y,
   output logic          done,
   output logic [VW-1:0] val
);
   localparam logic [VW-1:0] MAXV = '1;

   logic          busy_q;
   logic [VW-1:0] acc_q;
   logic [CW-1:0] x_q, y_q, left_q;
   logic [VW+CW-1:0] mul;
   logic [VW-1:0]    mul_sat;
   logic [2*CW-1:0]  xy;

   assign mul     = acc_q * x_q;
   assign mul_sat = (mul > {{CW{1'b0}}, MAXV}) ? MAXV : mul[VW-1:0];
   assign xy      = x_q * y_q;

   // R3: one multiply per cycle, saturating, then subtract x*y
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         acc_q  <= '0;
         x_q    <= '0;
         y_q    <= '0;
         left_q <= '0;
         done   <= 1'b0;
         val    <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy_q <= 1'b1;
            acc_q  <= VW'(1);
            x_q    <= x;
            y_q    <= y;
            left_q <= y;
         end else if (busy_q) begin
            if (left_q == '0) begin
               val    <= acc_q - VW'(xy);
               done   <= 1'b1;
               busy_q <= 1'b0;
            end else begin
               acc_q  <= mul_sat;
               left_q <= left_q - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/kg_prime_trial.sv
module kg_prime_trial #(
   parameter int VW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [VW-1:0] n,
   output logic          done,
   output logic          is_prime
);
   logic          busy_q;
   logic [VW-1:0] n_q, d_q, rem;
   logic [2*VW-1:0] dsq;

   assign dsq = d_q * d_q;
   assign rem = n_q % d_q;

   // one divisor per cycle while divisor squared does not exceed n
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         n_q      <= '0;
         d_q      <= VW'(2);
         done     <= 1'b0;
         is_prime <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy_q <= 1'b1;
            n_q    <= n;
            d_q    <= VW'(2);
         end else if (busy_q) begin
            if (n_q < VW'(2)) begin
               done <= 1'b1; is_prime <= 1'b0; busy_q <= 1'b0;
            end else if (dsq > {{VW{1'b0}}, n_q}) begin
               done <= 1'b1; is_prime <= 1'b1; busy_q <= 1'b0;
            end else if (rem == '0) begin
               done <= 1'b1; is_prime <= 1'b0; busy_q <= 1'b0;
            end else begin
               d_q <= d_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/charclass_keygen.sv
module charclass_keygen
   import keygen_pkg::*;
#(
   parameter int VW = 32,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [7:0]    in_byte,
   input  logic          in_last,
   output logic          busy,
   output logic          key_done,
   output logic          key_err,
   output logic [VW-1:0] key
);
   generate
      if (CW < 2) begin : g_bad_cw
         $error("charclass_keygen: CW must be at least 2");
      end
      if (VW < 2 * CW) begin : g_bad_vw
         $error("charclass_keygen: VW must hold the product of two counts");
      end
   endgenerate

   typedef enum logic [2:0] {ST_IN, ST_HP, ST_HQ, ST_UP, ST_DN} st_e;

   st_e           st_q;
   logic          sidx_q;
   logic [CW-1:0] px_q, py_q, qx_q, qy_q;
   logic [CW-1:0] win_x, win_y;
   logic [VW-1:0] pval_q, hi_q, cand_q, lowp_q;
   logic          h_go_q, h_done, t_go_q, t_done, t_prime;
   logic [VW-1:0] h_val;
   logic          take;
   logic [VW:0]   psum;

   assign busy = (st_q != ST_IN);
   // R8: bytes count only while collecting
   assign take = in_valid && (st_q == ST_IN);
   assign psum = {1'b0, lowp_q} + {1'b0, cand_q};

   kg_class_tally #(.CW(CW)) u_tally (
      .clk(clk), .rst_n(rst_n), .inc(take), .clr(in_last), .ch(in_byte),
      .win_x(win_x), .win_y(win_y)
   );

   kg_hash_eval #(.VW(VW), .CW(CW)) u_hash (
      .clk(clk), .rst_n(rst_n), .start(h_go_q),
      .x(st_q == ST_HQ ? qx_q : px_q), .y(st_q == ST_HQ ? qy_q : py_q),
      .done(h_done), .val(h_val)
   );

   kg_prime_trial #(.VW(VW)) u_trial (
      .clk(clk), .rst_n(rst_n), .start(t_go_q), .n(cand_q),
      .done(t_done), .is_prime(t_prime)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IN;
         sidx_q   <= 1'b0;
         px_q     <= '0; py_q <= '0; qx_q <= '0; qy_q <= '0;
         pval_q   <= '0; hi_q <= '0; cand_q <= '0; lowp_q <= '0;
         h_go_q   <= 1'b0;
         t_go_q   <= 1'b0;
         key_done <= 1'b0;
         key_err  <= 1'b0;
         key      <= '0;
      end else begin
         h_go_q   <= 1'b0;
         t_go_q   <= 1'b0;
         key_done <= 1'b0;
         unique case (st_q)
            ST_IN: if (take && in_last) begin
               // R4: first string gives p, second gives q
               if (!sidx_q) begin
                  px_q <= win_x; py_q <= win_y; sidx_q <= 1'b1;
               end else begin
                  qx_q <= win_x; qy_q <= win_y; sidx_q <= 1'b0;
                  st_q <= ST_HP; h_go_q <= 1'b1;
               end
            end
            ST_HP: if (h_done) begin
               pval_q <= h_val; st_q <= ST_HQ; h_go_q <= 1'b1;
            end
            ST_HQ: if (h_done) begin
               cand_q <= (h_val < pval_q) ? h_val : pval_q;
               hi_q   <= (h_val < pval_q) ? pval_q : h_val;
               st_q   <= ST_UP; t_go_q <= 1'b1;
            end
            ST_UP: if (t_done) begin
               if (t_prime) begin
                  lowp_q <= cand_q; cand_q <= hi_q;
                  st_q <= ST_DN; t_go_q <= 1'b1;
               end else if (cand_q == hi_q) begin
                  // R6: range exhausted without a prime
                  key <= '0; key_err <= 1'b1; key_done <= 1'b1; st_q <= ST_IN;
               end else begin
                  cand_q <= cand_q + 1'b1; t_go_q <= 1'b1;
               end
            end
            ST_DN: if (t_done) begin
               if (t_prime) begin
                  // R5: truncated average of the extreme primes
                  key <= VW'(psum >> 1); key_err <= 1'b0; key_done <= 1'b1;
                  st_q <= ST_IN;
               end else begin
                  cand_q <= cand_q - 1'b1; t_go_q <= 1'b1;
               end
            end
            default: st_q <= ST_IN;
         endcase
      end
   end
endmodule

// File: rtl/keygen_chk.sv
module keygen_chk #(
   parameter int VW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          key_done,
   input logic          key_err,
   input logic [VW-1:0] key
);
   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_done |=> !key_done);
   // R7
   key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !key_done |-> ($stable(key) && $stable(key_err)));
   // R6
   err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_done && key_err) |-> (key == '0));
   // R5
   key_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_done && !key_err) |-> (key >= VW'(2)));
   // R8
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> key_done);
   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_done |-> !busy);
   // R9
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (!key_done && !busy && !key_err && key == '0));
endmodule

bind charclass_keygen keygen_chk #(.VW(VW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy),
   .key_done(key_done), .key_err(key_err), .key(key)
);

// File: tb/sim_charclass_keygen.sv
module sim_charclass_keygen;
   localparam int VW = 16;
   localparam int CW = 8;
   localparam longint MAXV = (64'd1 << VW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [7:0]    in_byte = 8'h00;
   logic          in_last = 1'b0;
   logic          busy, k_done, k_err;
   logic [VW-1:0] k_val;

   int  nchk = 0, nfail = 0;
   bit  exp_pend = 0, got = 0, finished = 0;
   int  exp_key = 0;
   bit  exp_err = 0;
   string cur_tag = "";
   logic [VW-1:0] held_key = '0;

   always #2 clk = ~clk;

   charclass_keygen #(.VW(VW), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_last(in_last), .busy(busy), .key_done(k_done), .key_err(k_err),
      .key(k_val)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // ---------------- behavioural reference ----------------
   function automatic void hash_of(input byte s[$], output longint v);
      int c[4];
      int best;
      longint acc;
      c = '{0, 0, 0, 0};
      foreach (s[i]) begin
         int k;
         if (s[i] >= "a" && s[i] <= "z") k = 0;
         else if (s[i] >= "0" && s[i] <= "9") k = 1;
         else if (s[i] >= "A" && s[i] <= "Z") k = 2;
         else k = 3;
         if (c[k] < 255) c[k]++;
      end
      best = 0;
      for (int k = 1; k < 4; k++) if (c[k] > c[best]) best = k;
      acc = 1;
      for (int j = 0; j < c[(best + 1) % 4]; j++) begin
         acc = acc * c[best];
         if (acc > MAXV) acc = MAXV;
      end
      v = acc - c[best] * c[(best + 1) % 4];
   endfunction

   function automatic bit prime(input longint n);
      if (n < 2) return 0;
      for (longint d = 2; d * d <= n; d++) if (n % d == 0) return 0;
      return 1;
   endfunction

   function automatic void model(input byte s1[$], input byte s2[$], output int k, output bit e);
      longint p, q, lo, hi, a, b;
      bit fa;
      hash_of(s1, p);
      hash_of(s2, q);
      lo = (p < q) ? p : q;
      hi = (p < q) ? q : p;
      fa = 0; a = 0; b = 0;
      for (longint n = lo; n <= hi && !fa; n++) if (prime(n)) begin a = n; fa = 1; end
      if (!fa) begin k = 0; e = 1; return; end
      for (longint n = hi; n >= a; n--) if (prime(n)) begin b = n; break; end
      k = int'((a + b) / 2);
      e = 0;
   endfunction

   function automatic void to_q(input string t, output byte q[$]);
      q = {};
      for (int i = 0; i < t.len(); i++) q.push_back(t[i]);
   endfunction

   function automatic byte rchar();
      case ($urandom_range(0, 3))
         0: return byte'($urandom_range(97, 122));
         1: return byte'($urandom_range(48, 57));
         2: return byte'($urandom_range(65, 90));
         default: return byte'($urandom_range(33, 47));
      endcase
   endfunction

   // ---------------- per-clock comparison ----------------
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (k_done) begin
            if (!exp_pend) check(0, "R7 unexpected key_done", 1, 0);
            else begin
               check(k_val == exp_key && k_err == exp_err,
                     {cur_tag, " key/err as {err,key}"},
                     {k_err, 32'(k_val)}, {exp_err, 32'(exp_key)});
               exp_pend = 0;
               got = 1;
            end
         end else if (k_val != held_key) begin
            check(0, "R7 key changed without key_done", k_val, held_key);
         end
         held_key = k_val;
      end
   end

   task automatic send(input byte s[$]);
      foreach (s[i]) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_byte  = s[i];
         in_last  = (i == s.size() - 1);
      end
   endtask

   task automatic run_pair(input byte s1[$], input byte s2[$], input string tag,
                           input bit junk);
      int k;
      bit e;
      int guard;
      model(s1, s2, k, e);
      exp_key = k; exp_err = e; cur_tag = tag; got = 0;
      send(s1);
      send(s2);
      exp_pend = 1;
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      check(busy == 1'b1, "R8 busy after second last byte", busy, 1);
      guard = 0;
      while (!got && guard < 150000) begin
         if (junk && busy) begin
            // R8: offered while busy, must be ignored
            in_valid = 1'b1; in_byte = "!"; in_last = guard[0];
         end
         @(negedge clk);
         in_valid = 1'b0; in_last = 1'b0;
         guard++;
      end
      if (!got) check(0, {tag, " watchdog"}, 0, 1);
      check(busy == 1'b0, "R8 busy low after key", busy, 0);
   endtask

   initial begin
      byte x[$], y[$], s1[$], s2[$];
      repeat (3) @(negedge clk);
      // R9: reset state
      check(busy == 0 && k_done == 0 && k_err == 0 && k_val == 0,
            "R9 reset outputs", {busy, k_done, k_err}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      to_q("ade3010SH#@{}%", x);
      to_q("upes203IND#$^*t5", y);
      run_pair(x, y, "R1 R2 R3 R5 worked strings", 0);
      run_pair(y, x, "R4 swapped order", 0);

      to_q("aaa111", s1); to_q("qqqq11", s2);
      run_pair(s1, s2, "R2 tie lower class first", 0);
      to_q("BB##", s1);
      run_pair(s1, s2, "R2 tie class2 over class3", 0);
      to_q("aB1#", s1);
      run_pair(s1, s2, "R5 truncated average with prime 2", 1);
      // the junk offered above must not have shifted the string order
      run_pair(x, y, "R8 input ignored while busy", 0);

      to_q("abcdefghi12345678", s1);
      run_pair(s1, s1, "R6 saturated single composite", 0);
      to_q("ab", s2);
      run_pair(s1, s2, "R3 saturated upper end", 0);
      to_q("Q", s2);
      run_pair(s2, s2, "R6 range of one non-prime", 0);

      for (int r = 0; r < 30; r++) begin
         s1 = {}; s2 = {};
         for (int i = 0; i < $urandom_range(1, 8); i++) s1.push_back(rchar());
         for (int i = 0; i < $urandom_range(1, 8); i++) s2.push_back(rchar());
         run_pair(s1, s2, "R1 R2 R3 R4 R5 R6 random pair", 0);
      end

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      #(4 * 190000);
      if (!finished) begin
         finished = 1;
         check(0, "watchdog expired", 0, 1);
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule